// File: doc/BRIEF.md
# Synthesizer Command Decoder

This block is the serial front end of a frequency synthesizer controller. It acts as a slave on a four-wire serial link made of select, clock and data lines. It collects the bytes of one frame while select is low, and it acts on the frame when select goes high again. The first byte of a frame is a command character. The payload that follows is either a 32-bit binary word, sent least significant byte first, or eight uppercase ASCII hexadecimal digits, sent most significant digit first.

The block holds two tuning registers: the one in use (active) and a spare (standby). Each has a 32-bit value and a 2-bit tuning mode. It also holds a reference division ratio and a sticky request to store that ratio permanently. A valid frame updates these registers and produces a one-cycle update strobe. A malformed frame leaves every register as it was and produces a one-cycle invalid pulse instead. The frequency arithmetic, the PLL programming and the permanent storage are handled elsewhere.

The serial lines are brought into the system clock domain through two-stage synchronizers and edge detectors. The system clock must therefore run at least eight times faster than the serial bit rate.

Top module: `synth_cmd_decoder`

## Requirements
- R1: After reset, the active register holds 0 in channel mode, the standby register holds MAX_CHAN in channel mode, the reference divider holds REF_DIV_INIT, and the permanent-write request, the update strobe and the invalid pulse are all 0. The mode codes are 0 = channel, 1 = division ratio, 2 = kHz and 3 = MHz.
- R2: Each byte is received most significant bit first, one bit per rising edge of the serial clock while select is low. The frames 0x43 'C' and 0x44 'D' load the active register. The frames 0x63 'c' and 0x64 'd' load the standby register. Each of these frames carries a 4-byte little-endian value, and the mode becomes channel for 'C'/'c' and division ratio for 'D'/'d'. For example, 'D' 8C 0A 00 00 gives 2700.
- R3: The frames 0x4B 'K', 0x6B 'k', 0x4D 'M' and 0x6D 'm' carry 8 ASCII hex digits, most significant digit first, using only '0'-'9' and 'A'-'F'. Uppercase letters load the active register and lowercase letters load the standby register, with mode kHz for 'K'/'k' and MHz for 'M'/'m'. For example, "003D0900" gives 4000000.
- R4: The frame 0x52 'R' followed by a 4-byte little-endian value loads the reference divider.
- R5: The frame 0x72 'r' carries the 4-byte ratio twice, 9 bytes in total. When the two copies match, it loads the reference divider and sets the permanent-write request, which then stays set until reset.
- R6: The 1-byte frame 0x53 'S' swaps the value and the mode of the active and standby registers.
- R7: Any of the following makes the frame invalid: an unknown command byte, a character other than '0'-'9' or 'A'-'F' in a hex payload, a byte count that differs from the command's frame length, or a select release in the middle of a byte. An invalid frame raises the invalid pulse and changes no register.
- R8: An 'r' frame whose two copies differ is invalid and changes no register.
- R9: When select rises, the update strobe (for a valid frame) or the invalid pulse (otherwise) is high for exactly one system clock. The pulse appears on the third system clock edge after the rise, in the same cycle that the registers change. Registers change at no other time.
- R10: A select low period during which no serial clock edge occurs produces neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_mosi | input | 1 | Serial data in |
| act_val | output | W | Active tuning value |
| act_mode | output | 2 | Active tuning mode |
| stb_val | output | W | Standby tuning value |
| stb_mode | output | 2 | Standby tuning mode |
| ref_div | output | W | Reference division ratio |
| nv_ref_req | output | 1 | Sticky request for a permanent reference write |
| upd_stb | output | 1 | One-cycle pulse after a valid frame |
| bad_cmd | output | 1 | One-cycle pulse after an invalid frame |

## Verification
The hardest cases to reach from the ports are frames that are wrong only in their shape. These are a select release after a partial byte, a frame with one byte too many, and an 'r' frame whose second copy differs from the first in a single byte. The bench reaches them through one frame-sending task that takes an arbitrary byte list and a bit count for the final byte. It then drives truncated, overlong, lowercase-hex and mismatched-copy frames between valid frames, so that any stray register write would show up against the model.

// File: rtl/synth_cmd_decoder.sv
module synth_cmd_decoder #(
  parameter int          W            = 32,
  parameter logic [31:0] MAX_CHAN     = 32'd255,
  parameter logic [31:0] REF_DIV_INIT = 32'd20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spi_cs_n,
  input  logic         spi_sck,
  input  logic         spi_mosi,
  output logic [W-1:0] act_val,
  output logic [1:0]   act_mode,
  output logic [W-1:0] stb_val,
  output logic [1:0]   stb_mode,
  output logic [W-1:0] ref_div,
  output logic         nv_ref_req,
  output logic         upd_stb,
  output logic         bad_cmd
);
  localparam int NB    = W / 8;
  localparam int NH    = W / 4;
  localparam int CW    = $clog2(2 * NB + 2) + 1;
  localparam logic [CW-1:0] LEN_BIN = CW'(NB + 1);
  localparam logic [CW-1:0] LEN_HEX = CW'(NH + 1);
  localparam logic [CW-1:0] LEN_DUP = CW'(2 * NB + 1);
  localparam logic [CW-1:0] NB_C    = CW'(NB);
  localparam logic [1:0] MODE_CHAN = 2'd0, MODE_RATIO = 2'd1, MODE_KHZ = 2'd2, MODE_MHZ = 2'd3;

  logic [2:0] cs_q, sck_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic [CW-1:0] byte_cnt;
  logic [7:0] cmd;
  logic [W-1:0] data;
  logic err, got_bits;

  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sel      = ~cs_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2] & sel;
  wire [7:0] byte_in = {sh, mosi_q[1]};
  wire byte_done = sck_rise && (bit_cnt == 3'd7);

  function automatic logic [CW-1:0] frame_len(input logic [7:0] c);
    case (c)
      8'h43, 8'h63, 8'h44, 8'h64, 8'h52: frame_len = LEN_BIN;
      8'h4B, 8'h6B, 8'h4D, 8'h6D:        frame_len = LEN_HEX;
      8'h72:                             frame_len = LEN_DUP;
      8'h53:                             frame_len = CW'(1);
      default:                           frame_len = '0;
    endcase
  endfunction

  function automatic logic is_hex_cmd(input logic [7:0] c);
    is_hex_cmd = (c == 8'h4B) || (c == 8'h6B) || (c == 8'h4D) || (c == 8'h6D);
  endfunction

  wire hex_digit = (byte_in >= 8'h30 && byte_in <= 8'h39);
  wire hex_alpha = (byte_in >= 8'h41 && byte_in <= 8'h46);
  wire [3:0] nibble = hex_alpha ? byte_in[3:0] + 4'd9 : byte_in[3:0];

  logic [CW-1:0] slot;
  always_comb slot = (byte_cnt > NB_C) ? byte_cnt - NB_C - CW'(1) : byte_cnt - CW'(1);

  wire frame_ok = got_bits && !err && (bit_cnt == 3'd0) && (frame_len(cmd) != '0)
                  && (byte_cnt == frame_len(cmd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 3'b111; sck_q <= '0; mosi_q <= '0;
    end else begin
      cs_q   <= {cs_q[1:0], spi_cs_n};
      sck_q  <= {sck_q[1:0], spi_sck};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; sh <= '0; byte_cnt <= '0; cmd <= '0;
      data <= '0; err <= 1'b0; got_bits <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt <= '0; byte_cnt <= '0; data <= '0; err <= 1'b0; got_bits <= 1'b0; cmd <= '0;
    end else if (sck_rise) begin
      got_bits <= 1'b1;
      bit_cnt  <= bit_cnt + 3'd1;
      sh       <= byte_in[6:0];
      if (byte_done) begin
        if (byte_cnt != '1) byte_cnt <= byte_cnt + CW'(1);
        if (byte_cnt == '0) begin
          cmd <= byte_in;
          if (frame_len(byte_in) == '0) err <= 1'b1;
        end else if (byte_cnt >= frame_len(cmd)) begin
          err <= 1'b1;
        end else if (is_hex_cmd(cmd)) begin
          if (!(hex_digit || hex_alpha)) err <= 1'b1;
          else data <= {data[W-5:0], nibble};
        end else if (byte_cnt > NB_C) begin
          if (data[8*slot +: 8] != byte_in) err <= 1'b1;
        end else begin
          data[8*slot +: 8] <= byte_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_val <= '0;                act_mode <= MODE_CHAN;
      stb_val <= W'(MAX_CHAN);      stb_mode <= MODE_CHAN;
      ref_div <= W'(REF_DIV_INIT);  nv_ref_req <= 1'b0;
      upd_stb <= 1'b0;              bad_cmd <= 1'b0;
    end else begin
      upd_stb <= cs_rise && frame_ok;
      bad_cmd <= cs_rise && got_bits && !frame_ok;
      if (cs_rise && frame_ok) begin
        case (cmd)
          8'h43: begin act_val <= data; act_mode <= MODE_CHAN;  end
          8'h63: begin stb_val <= data; stb_mode <= MODE_CHAN;  end
          8'h44: begin act_val <= data; act_mode <= MODE_RATIO; end
          8'h64: begin stb_val <= data; stb_mode <= MODE_RATIO; end
          8'h4B: begin act_val <= data; act_mode <= MODE_KHZ;   end
          8'h6B: begin stb_val <= data; stb_mode <= MODE_KHZ;   end
          8'h4D: begin act_val <= data; act_mode <= MODE_MHZ;   end
          8'h6D: begin stb_val <= data; stb_mode <= MODE_MHZ;   end
          8'h52: ref_div <= data;
          8'h72: begin ref_div <= data; nv_ref_req <= 1'b1; end
          8'h53: begin
            act_val <= stb_val; act_mode <= stb_mode;
            stb_val <= act_val; stb_mode <= act_mode;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_cmd_decoder_chk.sv
module synth_cmd_decoder_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] act_val,
  input logic [1:0]   act_mode,
  input logic [W-1:0] stb_val,
  input logic [1:0]   stb_mode,
  input logic [W-1:0] ref_div,
  input logic         nv_ref_req,
  input logic         upd_stb,
  input logic         bad_cmd
);
  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(upd_stb && bad_cmd));
  // R9
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n) upd_stb |=> !upd_stb);
  // R9
  bad_single_chk: assert property (@(posedge clk) disable iff (!rst_n) bad_cmd |=> !bad_cmd);
  // R7
  bad_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> ($stable(act_val) && $stable(stb_val) && $stable(ref_div)
                 && $stable(act_mode) && $stable(stb_mode) && $stable(nv_ref_req)));
  // R9
  quiet_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> ($stable(act_val) && $stable(stb_val) && $stable(ref_div)
                  && $stable(act_mode) && $stable(stb_mode)));
  // R5
  nv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) nv_ref_req |=> nv_ref_req);
endmodule

bind synth_cmd_decoder synth_cmd_decoder_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_val(act_val), .act_mode(act_mode),
  .stb_val(stb_val), .stb_mode(stb_mode), .ref_div(ref_div),
  .nv_ref_req(nv_ref_req), .upd_stb(upd_stb), .bad_cmd(bad_cmd)
);

// File: tb/synth_cmd_decoder_bench.sv
module synth_cmd_decoder_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic [W-1:0] act_val, stb_val, ref_div;
  logic [1:0] act_mode, stb_mode;
  logic nv_ref_req, upd_stb, bad_cmd;

  always #4 clk = ~clk;

  synth_cmd_decoder #(.W(W), .MAX_CHAN(32'd255), .REF_DIV_INIT(32'd20)) u_synth_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .act_val(act_val), .act_mode(act_mode), .stb_val(stb_val), .stb_mode(stb_mode),
    .ref_div(ref_div), .nv_ref_req(nv_ref_req), .upd_stb(upd_stb), .bad_cmd(bad_cmd));

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [31:0] m_act = 0, m_stb = 255, m_ref = 20;
  logic [1:0]  m_am = 0, m_sm = 0;
  logic m_nv = 0, m_upd = 0, m_bad = 0;
  logic [7:0] frm[$];
  bit done = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (act_val !== m_act || act_mode !== m_am || stb_val !== m_stb || stb_mode !== m_sm ||
        ref_div !== m_ref || nv_ref_req !== m_nv || upd_stb !== m_upd || bad_cmd !== m_bad) begin
      errors++;
      $display("FAIL %s model compare actual=%h/%0d %h/%0d %h %b %b %b expected=%h/%0d %h/%0d %h %b %b %b",
               cur_req, act_val, act_mode, stb_val, stb_mode, ref_div, nv_ref_req, upd_stb, bad_cmd,
               m_act, m_am, m_stb, m_sm, m_ref, m_nv, m_upd, m_bad);
    end
  end

  function automatic int hexval(input logic [7:0] c);
    if (c >= 8'h30 && c <= 8'h39) return int'(c - 8'h30);
    if (c >= 8'h41 && c <= 8'h46) return int'(c - 8'h41) + 10;
    return -1;
  endfunction

  task automatic model_apply(input int last_bits);
    int n = frm.size();
    int need;
    logic [31:0] v = 0, v2 = 0;
    bit ok = 1;
    if (n == 0) return;
    if (last_bits != 8) ok = 0;
    case (frm[0])
      8'h43, 8'h63, 8'h44, 8'h64, 8'h52: need = 5;
      8'h4B, 8'h6B, 8'h4D, 8'h6D: need = 9;
      8'h72: need = 9;
      8'h53: need = 1;
      default: need = 0;
    endcase
    if (need == 0 || n != need) ok = 0;
    if (ok && need == 9 && frm[0] != 8'h72) begin
      for (int i = 1; i < 9; i++) begin
        int h = hexval(frm[i]);
        if (h < 0) ok = 0; else v = (v << 4) | 32'(h);
      end
    end else if (ok && need >= 5) begin
      for (int i = 0; i < 4; i++) v = v + (32'(frm[1+i]) << (8*i));
      if (frm[0] == 8'h72) begin
        for (int i = 0; i < 4; i++) v2 = v2 + (32'(frm[5+i]) << (8*i));
        if (v2 != v) ok = 0;
      end
    end
    if (ok) begin
      case (frm[0])
        8'h43: begin m_act = v; m_am = 0; end
        8'h63: begin m_stb = v; m_sm = 0; end
        8'h44: begin m_act = v; m_am = 1; end
        8'h64: begin m_stb = v; m_sm = 1; end
        8'h4B: begin m_act = v; m_am = 2; end
        8'h6B: begin m_stb = v; m_sm = 2; end
        8'h4D: begin m_act = v; m_am = 3; end
        8'h6D: begin m_stb = v; m_sm = 3; end
        8'h52: m_ref = v;
        8'h72: begin m_ref = v; m_nv = 1; end
        8'h53: begin
          logic [31:0] tv = m_act; logic [1:0] tm = m_am;
          m_act = m_stb; m_am = m_sm; m_stb = tv; m_sm = tm;
        end
        default: ;
      endcase
    end
    m_upd = ok; m_bad = !ok;
  endtask

  task automatic send(input int last_bits, input string req);
    cur_req = req;
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < frm.size(); i++) begin
      int nb = (i == frm.size() - 1) ? last_bits : 8;
      for (int b = 7; b > 7 - nb; b--) begin
        spi_mosi = frm[i][b];
        repeat (8) @(negedge clk); spi_sck = 1'b1;
        repeat (8) @(negedge clk); spi_sck = 1'b0;
      end
    end
    repeat (8) @(negedge clk); spi_cs_n = 1'b1;
    repeat (3) @(posedge clk);
    model_apply(last_bits);
    @(posedge clk);
    m_upd = 0; m_bad = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_str(input string s);
    for (int i = 0; i < s.len(); i++) frm.push_back(s[i]);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", "act_val", act_val, 0);
    check("R1", "stb_val", stb_val, 255);
    check("R1", "ref_div", ref_div, 20);
    check("R1", "nv_ref_req", 32'(nv_ref_req), 0);

    // R2
    frm = {8'h44, 8'h8C, 8'h0A, 8'h00, 8'h00}; send(8, "R2");
    check("R2", "D ratio", act_val, 2700); check("R2", "D mode", 32'(act_mode), 1);
    frm = {8'h63, 8'h05, 8'h00, 8'h00, 8'h00}; send(8, "R2");
    check("R2", "c standby", stb_val, 5);
    frm = {8'h64, 8'h78, 8'h56, 8'h34, 8'h12}; send(8, "R2");
    check("R2", "d standby", stb_val, 32'h12345678); check("R2", "d mode", 32'(stb_mode), 1);

    // R3
    frm = {8'h4B}; push_str("003D0900"); send(8, "R3");
    check("R3", "K kHz", act_val, 4000000); check("R3", "K mode", 32'(act_mode), 2);
    frm = {8'h6D}; push_str("00000FA0"); send(8, "R3");
    check("R3", "m MHz", stb_val, 4000); check("R3", "m mode", 32'(stb_mode), 3);

    // R6
    frm = {8'h53}; send(8, "R6");
    check("R6", "swap act", act_val, 4000); check("R6", "swap stb", stb_val, 4000000);
    check("R6", "swap act mode", 32'(act_mode), 3);

    // R4
    frm = {8'h52, 8'h28, 8'h00, 8'h00, 8'h00}; send(8, "R4");
    check("R4", "ref", ref_div, 40);

    // R8
    frm = {8'h72, 8'h14, 8'h00, 8'h00, 8'h00, 8'h14, 8'h01, 8'h00, 8'h00}; send(8, "R8");
    check("R8", "ref kept", ref_div, 40); check("R8", "nv kept", 32'(nv_ref_req), 0);

    // R5
    frm = {8'h72, 8'h14, 8'h00, 8'h00, 8'h00, 8'h14, 8'h00, 8'h00, 8'h00}; send(8, "R5");
    check("R5", "ref", ref_div, 20); check("R5", "nv set", 32'(nv_ref_req), 1);

    // R7
    frm = {8'h58, 8'h01}; send(8, "R7");
    frm = {8'h4B}; push_str("003d0900"); send(8, "R7");
    check("R7", "lowercase hex kept", act_val, 4000);
    frm = {8'h43, 8'h01, 8'h02}; send(8, "R7");
    frm = {8'h53, 8'h00}; send(8, "R7");
    check("R7", "long S kept", act_val, 4000);
    frm = {8'h43, 8'h32, 8'h00, 8'h00, 8'h00}; send(5, "R7");
    check("R7", "cut byte kept", act_val, 4000);
    check("R5", "nv still set", 32'(nv_ref_req), 1);

    // R10
    frm = {}; send(8, "R10");

    // R2 / R9
    frm = {8'h43, 8'h32, 8'h00, 8'h00, 8'h00}; send(8, "R9");
    check("R2", "C channel", act_val, 50); check("R2", "C mode", 32'(act_mode), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule